// File: doc/BRIEF.md
# Modulo Circular Pointer Updater

This block computes the next value of an address pointer while keeping it inside a circular buffer of any length from 2 upward. The caller presents the current pointer, a modifier equal to the buffer length minus one, a signed step (a post-increment, a post-decrement or a larger offset), the index of the pointer being updated and a modulo enable. The block finds the buffer window from the pointer and modifier alone and returns the corrected pointer plus a flag that says a correction took place.

Only the two lowest pointer indices may use circular arithmetic. Every other index, and any index while the modulo enable is low, takes the plain linear path, where the result is the pointer plus the step, wrapping only at the top of the address space. The result is registered, so it appears one clock after the request.

The window base is the pointer with its low k bits cleared, where 2^k is the smallest power of two not below the buffer length; the top of the window is the base plus the modifier. A step magnitude larger than the buffer length is outside the supported use.

Top module: `circ_ptr_update`

## Requirements
- R1: While reset is asserted and on the first cycle after its release with no request, out_valid, wrap and ptr_out are all zero.
- R2: For a pointer index of 2 or more, ptr_out is (ptr_in + step) modulo 2^ADDR_W and wrap is 0, whatever mod_en and modifier hold.
- R3: For pointer index 0 or 1 with mod_en low, ptr_out is (ptr_in + step) modulo 2^ADDR_W and wrap is 0.
- R4: In circular mode (mod_en high, pointer index 0 or 1) a result that stays between base and base + modifier is returned unchanged with wrap 0.
- R5: In circular mode a raw result above base + modifier has (modifier + 1) subtracted and wrap is 1, so ptr_out always lies in the window.
- R6: In circular mode a raw result below base, including a decrement from address 0, has (modifier + 1) added and wrap is 1.
- R7: The base is ptr_in with all bits at and below the most significant set bit of modifier cleared, so lengths that are not powers of two (for example 9 or 45) wrap at base + modifier.
- R8: A step that jumps over a window edge by several locations, up to a magnitude equal to the buffer length, lands at the same place as the equivalent number of single steps.
- R9: ptr_out and wrap are registered: out_valid is high exactly one cycle after in_valid, and wrap is never high without out_valid.
- R10: The largest length of 16384 (modifier 0x3FFF) wraps correctly in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| ptr_idx | input | IDX_W (3) | Index of the pointer being updated |
| mod_en | input | 1 | Requests circular arithmetic |
| ptr_in | input | ADDR_W (24) | Current pointer value |
| modifier | input | MOD_W (14) | Buffer length minus one |
| step | input | ADDR_W (24) | Signed two's-complement step |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| ptr_out | output | ADDR_W (24) | Updated pointer |
| wrap | output | 1 | A correction by the buffer length was applied |

## Verification
A wrong window mask or base shows at ptr_out in the cycle right after the request: the returned pointer leaves the window, or lands one buffer length away from where it should. A wrong eligibility decision shows the same cycle as a linear result where a wrapped one was due, or as a spurious wrap pulse. Odd lengths, jumps that skip an edge, decrements from address zero and the largest length are the cases most likely to expose such faults, so the stimulus dwells on them.

// File: rtl/circ_ptr_pkg.sv
package circ_ptr_pkg;

    localparam int ADDR_W = 24;
    localparam int MOD_W  = 14;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t ptr;
        logic  wrap;
        logic  vld;
    } upd_s;

endpackage

// File: rtl/circ_bound.sv
// Derives the circular window from pointer and modifier.
module circ_bound #(
    parameter int ADDR_W = 24,
    parameter int MOD_W  = 14
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [MOD_W-1:0]  modifier,
    output logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] upper
);
    localparam int PAD_W = ADDR_W - MOD_W;

    logic [MOD_W-1:0] smear;

    // Ones from the top set bit of the modifier downward: 2^k - 1.
    assign smear[MOD_W-1] = modifier[MOD_W-1];
    genvar gi;
    generate
        for (gi = MOD_W - 2; gi >= 0; gi--) begin : g_smear
            assign smear[gi] = smear[gi+1] | modifier[gi];
        end
    endgenerate

    always_comb begin
        mask  = {{PAD_W{1'b0}}, smear};
        base  = ptr & ~mask;
        upper = base + {{PAD_W{1'b0}}, modifier};
    end
endmodule

// File: rtl/circ_wrap.sv
// Adds the step and folds the result back into the window.
module circ_wrap #(
    parameter int ADDR_W = 24,
    parameter int MOD_W  = 14
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] step,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] upper,
    input  logic [MOD_W-1:0]  modifier,
    input  logic              mod_act,
    output logic [ADDR_W-1:0] res,
    output logic              wrap_hit
);
    localparam int EXT_W = ADDR_W + 2;

    logic signed [EXT_W-1:0] raw_s, base_s, upper_s, size_s, corr_s;

    always_comb begin
        raw_s    = $signed({2'b00, ptr}) + $signed({{2{step[ADDR_W-1]}}, step});
        base_s   = $signed({2'b00, base});
        upper_s  = $signed({2'b00, upper});
        size_s   = $signed(EXT_W'({1'b0, modifier}) + EXT_W'(1));
        corr_s   = raw_s;
        wrap_hit = 1'b0;
        if (mod_act) begin
            if (raw_s > upper_s) begin
                corr_s   = raw_s - size_s;
                wrap_hit = 1'b1;
            end else if (raw_s < base_s) begin
                corr_s   = raw_s + size_s;
                wrap_hit = 1'b1;
            end
        end
        res = corr_s[ADDR_W-1:0];
    end
endmodule

// File: rtl/circ_ptr_update.sv
module circ_ptr_update
    import circ_ptr_pkg::*;
#(
    parameter int IDX_W       = 3,
    parameter int NUM_MOD_PTR = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic [IDX_W-1:0]                 ptr_idx,
    input  logic                             mod_en,
    input  logic [circ_ptr_pkg::ADDR_W-1:0]  ptr_in,
    input  logic [circ_ptr_pkg::MOD_W-1:0]   modifier,
    input  logic [circ_ptr_pkg::ADDR_W-1:0]  step,
    output logic                             out_valid,
    output logic [circ_ptr_pkg::ADDR_W-1:0]  ptr_out,
    output logic                             wrap
);
    logic [ADDR_W-1:0] mask, base, upper, res;
    logic              mod_act, wrap_hit;
    upd_s              st_d, st_q;

    assign mod_act = mod_en && (ptr_idx < IDX_W'(NUM_MOD_PTR));

    circ_bound #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) bound_i (
        .ptr      (ptr_in),
        .modifier (modifier),
        .mask     (mask),
        .base     (base),
        .upper    (upper)
    );

    circ_wrap #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) wrap_i (
        .ptr      (ptr_in),
        .step     (step),
        .base     (base),
        .upper    (upper),
        .modifier (modifier),
        .mod_act  (mod_act),
        .res      (res),
        .wrap_hit (wrap_hit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_valid;
        st_d.wrap = in_valid && wrap_hit;
        if (in_valid) begin
            st_d.ptr = res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign ptr_out   = st_q.ptr;
    assign wrap      = st_q.wrap;

    // Wrap pulse only accompanies a result.
    assert_wrap_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> out_valid);

    // One-cycle latency.
    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_no_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // Linear path never reports a correction.
    assert_linear_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mod_act) |=> !wrap);

    // Circular result stays inside the window given by the bound logic.
    assert_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mod_act) |=>
            ((ptr_out - $past(base)) <= ADDR_W'($past(modifier))));
endmodule

// File: tb/circ_ptr_update_tb_top.sv
`timescale 1ns/1ps
module circ_ptr_update_tb_top;
    localparam int AW = 24;
    localparam int MW = 14;
    localparam int NV = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    ptr_idx = '0;
    logic          mod_en = 1'b0;
    logic [AW-1:0] ptr_in = '0;
    logic [MW-1:0] modifier = '0;
    logic [AW-1:0] step = '0;
    logic          out_valid, wrap;
    logic [AW-1:0] ptr_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    circ_ptr_update dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ptr_idx(ptr_idx),
        .mod_en(mod_en), .ptr_in(ptr_in), .modifier(modifier), .step(step),
        .out_valid(out_valid), .ptr_out(ptr_out), .wrap(wrap)
    );

    // Vectors: idx, en, ptr, modifier, step, expected ptr, expected wrap, requirement.
    localparam logic [2:0]    V_IDX [NV] = '{0,0,1,0,1,0,2,0,0,0,0,0,7,1,0};
    localparam logic          V_EN  [NV] = '{1,1,1,1,1,1,1,0,1,1,1,1,1,1,1};
    localparam logic [AW-1:0] V_PTR [NV] = '{
        24'h000100, 24'h000108, 24'h000100, 24'h000106, 24'h000102,
        24'h000105, 24'h000108, 24'h000108, 24'h000000, 24'h004000,
        24'h007FFF, 24'h00012C, 24'hFFFFFF, 24'h000120, 24'h000103};
    localparam logic [MW-1:0] V_MOD [NV] = '{
        14'h8, 14'h8, 14'h8, 14'h8, 14'h8,
        14'h8, 14'h8, 14'h8, 14'h8, 14'h3FFF,
        14'h3FFF, 14'h2C, 14'h8, 14'h2C, 14'h8};
    localparam logic [AW-1:0] V_STP [NV] = '{
        24'h000001, 24'h000001, 24'hFFFFFF, 24'h000005, 24'hFFFFFC,
        24'h000009, 24'h000001, 24'h000001, 24'hFFFFFF, 24'hFFFFFF,
        24'h000001, 24'h000003, 24'h000001, 24'hFFFFDF, 24'h000000};
    localparam logic [AW-1:0] V_EXP [NV] = '{
        24'h000101, 24'h000100, 24'h000108, 24'h000102, 24'h000107,
        24'h000105, 24'h000109, 24'h000109, 24'h000008, 24'h007FFF,
        24'h004000, 24'h000102, 24'h000000, 24'h00012C, 24'h000103};
    localparam logic          V_WR  [NV] = '{0,1,1,1,1,1,0,0,1,1,1,1,0,1,0};
    // 0 R4 inside, 1 R5 top edge, 2 R6 bottom edge, 3-5 R8 jumps,
    // 6 R2 index 2, 7 R3 enable low, 8 R6 from address 0,
    // 9-10 R10 largest length, 11 and 13 R7 length 45, 12 R2 address rollover, 14 R4 zero step.
    localparam int V_REQ [NV] = '{4,5,6,8,8,8,2,3,6,10,10,7,2,7,4};

    task automatic chk(input int rq, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic issue(input int i);
        @(negedge clk);
        in_valid = 1'b1;
        ptr_idx  = V_IDX[i];
        mod_en   = V_EN[i];
        ptr_in   = V_PTR[i];
        modifier = V_MOD[i];
        step     = V_STP[i];
        @(negedge clk);
        in_valid = 1'b0;
        chk(9, "out_valid", AW'(out_valid), AW'(1));
        chk(V_REQ[i], "ptr_out", ptr_out, V_EXP[i]);
        chk(V_REQ[i], "wrap", AW'(wrap), AW'(V_WR[i]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(1, "reset out_valid", AW'(out_valid), '0);
        chk(1, "reset ptr_out", ptr_out, '0);
        chk(1, "reset wrap", AW'(wrap), '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after release
        chk(1, "idle out_valid", AW'(out_valid), '0);
        chk(1, "idle ptr_out", ptr_out, '0);

        for (int i = 0; i < NV; i++) issue(i);

        // R9: no request, no result and no wrap pulse
        @(negedge clk);
        chk(9, "idle valid", AW'(out_valid), '0);
        chk(9, "idle wrap", AW'(wrap), '0);

        // R5: back-to-back wraps, each pulses wrap
        @(negedge clk);
        in_valid = 1'b1; ptr_idx = 3'd1; mod_en = 1'b1;
        ptr_in = 24'h000208; modifier = 14'h8; step = 24'h000002;
        @(negedge clk);
        chk(5, "b2b first ptr", ptr_out, 24'h000201);
        chk(5, "b2b first wrap", AW'(wrap), AW'(1));
        ptr_in = 24'h000201; step = 24'h000001;
        @(negedge clk);
        in_valid = 1'b0;
        chk(4, "b2b second ptr", ptr_out, 24'h000202);
        chk(4, "b2b second wrap", AW'(wrap), '0);

        // R1: reset clears a held result
        rst_n = 1'b0;
        @(negedge clk);
        chk(1, "re-reset ptr", ptr_out, '0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule